// File: doc/BRIEF.md
# I2C Bit-Clock Divider

This block produces the half-period timing step for an I2C master engine. It works from the system clock through four cascaded counters. The first is a half-period counter. The second is a power-of-two prescaler whose exponent comes from a 3-bit field. The third is an (M+1) divider. The last is a fixed divide-by-ten stage. The block emits one single-cycle tick each time the whole cascade reaches its terminal count. The bus engine advances SCL by one half period per tick, so the tick rate is twice the SCL rate.

Software loads two registers: an 8-bit half-period value and a control byte that holds M and N. A write is first held as a pending setting. While the block runs, the pending setting moves into the active counters only at a full-cascade terminal count, so no period is ever cut short. While the block is disabled, the counters are held at zero and the pending setting is copied through at once. The register write strobes are plain control pins with no handshake. The tick is a plain strobe and cannot be stalled.

Top module: `i2c_bitclk_div`

## Requirements
- R1: With an active setting of half-period value H, exponent N and divider M, consecutive ticks are exactly (H+1) * 2^N * (M+1) * 10 system-clock cycles apart, so SCL runs at sysclk / (2*(H+1)) / 2^N / (M+1) / 10.
- R2: In a control-byte write, M is taken from bits 6:3 and N from bits 2:0. Bit 7 has no effect on the tick spacing.
- R3: An active half-period value below 5 (including 0 and 2) behaves exactly as the value 5.
- R4: After reset the tick is low and the setting is H = 0x18, M = 2, N = 0, which gives a tick spacing of 750 cycles without any register write.
- R5: Every tick is high for exactly one clock cycle.
- R6: While the enable input is low, the tick stays low and the counters are cleared. The first tick after the enable input rises appears P cycles later, where P is the R1 spacing of the current setting.
- R7: A write made while running does not change the period in progress. The next tick comes at the old spacing, and the new spacing applies from that tick onward.
- R8: Every M value from 0 to 15 and every N value from 0 to 7 is accepted by the hardware. The extreme N = 7 produces the R1 spacing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Run enable; low holds the counters cleared |
| hp_we | input | 1 | Write strobe for the half-period register |
| hp_wdata | input | 8 | Half-period value |
| ctl_we | input | 1 | Write strobe for the control byte |
| ctl_wdata | input | 8 | Control byte: M in bits 6:3, N in bits 2:0 |
| tick | output | 1 | Single-cycle half-period step |

## Verification
The tick is registered. If the enable input is first sampled high at clock edge 1, the first tick is visible in the cycle after edge P. Later ticks are visible every P cycles after that. The bench drives inputs and samples the tick on falling edges. It counts falling edges from the one where the enable input or the previous tick was seen, and compares that count with P computed from R1. The count includes the cycles spent on a mid-run write, so the old and new spacings for R7 are measured across the update.

// File: rtl/i2c_bitclk_div_pkg.sv
package i2c_bitclk_div_pkg;
  localparam int HP_W    = 8;
  localparam int M_W     = 4;
  localparam int N_W     = 3;
  localparam int CNT_W   = 8;
  localparam int HP_MIN  = 5;
  localparam int DEC_DIV = 10;
  localparam int NSTAGE  = 4;

  localparam logic [HP_W-1:0] DEF_HP = 8'h18;
  localparam logic [M_W-1:0]  DEF_M  = 4'd2;
  localparam logic [N_W-1:0]  DEF_N  = 3'd0;

  typedef struct packed {
    logic [HP_W-1:0] hp;
    logic [M_W-1:0]  m;
    logic [N_W-1:0]  n;
  } divcfg_t;
endpackage

// File: rtl/i2c_bitclk_cfg.sv
module i2c_bitclk_cfg
  import i2c_bitclk_div_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            wrap_all,
  input  logic            hp_we,
  input  logic [HP_W-1:0] hp_wdata,
  input  logic            ctl_we,
  input  logic [7:0]      ctl_wdata,
  output divcfg_t         act_cfg
);
  divcfg_t pend_q, act_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '{hp: DEF_HP, m: DEF_M, n: DEF_N};
    end else begin
      if (hp_we)  pend_q.hp <= hp_wdata;
      if (ctl_we) begin
        pend_q.m <= ctl_wdata[6:3];
        pend_q.n <= ctl_wdata[2:0];
      end
    end
  end

  // Active setting only moves at a full terminal count or while stopped
  always_ff @(posedge clk) begin
    if (!rst_n)                act_q <= '{hp: DEF_HP, m: DEF_M, n: DEF_N};
    else if (!run || wrap_all) act_q <= pend_q;
  end

  always_comb begin
    act_cfg = act_q;
    if (act_q.hp < HP_W'(HP_MIN)) act_cfg.hp = HP_W'(HP_MIN);
  end

  p_hold_cfg_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !wrap_all) |=> $stable(act_q))
    else $error("active setting changed mid-period");
endmodule

// File: rtl/i2c_bitclk_stage.sv
module i2c_bitclk_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         step,
  input  logic [W-1:0] limit,
  output logic         wrap
);
  logic [W-1:0] cnt_q;

  assign wrap = step && (cnt_q == limit);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) cnt_q <= '0;
    else if (step)      cnt_q <= (cnt_q == limit) ? '0 : cnt_q + 1'b1;
  end

  p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q <= limit))
    else $error("stage count beyond its limit");
endmodule

// File: rtl/i2c_bitclk_div.sv
module i2c_bitclk_div
  import i2c_bitclk_div_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       hp_we,
  input  logic [7:0] hp_wdata,
  input  logic       ctl_we,
  input  logic [7:0] ctl_wdata,
  output logic       tick
);
  divcfg_t                 cfg;
  logic [NSTAGE:0]         carry;
  logic [CNT_W-1:0]        lim [NSTAGE];
  logic                    tick_q;

  i2c_bitclk_cfg u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (en),
    .wrap_all (carry[NSTAGE]),
    .hp_we    (hp_we),
    .hp_wdata (hp_wdata),
    .ctl_we   (ctl_we),
    .ctl_wdata(ctl_wdata),
    .act_cfg  (cfg)
  );

  // Stage limits: half period, 2^N prescale, M+1, fixed decade
  always_comb begin
    lim[0] = CNT_W'(cfg.hp);
    lim[1] = CNT_W'((CNT_W'(1) << cfg.n) - CNT_W'(1));
    lim[2] = CNT_W'(cfg.m);
    lim[3] = CNT_W'(DEC_DIV - 1);
  end

  assign carry[0] = en;

  for (genvar g = 0; g < NSTAGE; g++) begin : g_stage
    i2c_bitclk_stage #(.W(CNT_W)) u_stg (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (en),
      .step (carry[g]),
      .limit(lim[g]),
      .wrap (carry[g+1])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) tick_q <= 1'b0;
    else        tick_q <= en && carry[NSTAGE];
  end

  assign tick = tick_q;

  p_tick_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick)
    else $error("tick wider than one cycle");

  p_quiet_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !tick)
    else $error("tick while disabled");
endmodule

// File: tb/sim_i2c_bitclk_div.sv
module sim_i2c_bitclk_div;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic       hp_we = 1'b0;
  logic [7:0] hp_wdata = '0;
  logic       ctl_we = 1'b0;
  logic [7:0] ctl_wdata = '0;
  logic       tick;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  i2c_bitclk_div u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .hp_we(hp_we), .hp_wdata(hp_wdata),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .tick(tick)
  );

  localparam int NV = 6;
  localparam logic [7:0] V_HP  [NV] = '{8'd5,  8'd2,  8'd7,  8'd5,  8'd9,  8'd5};
  localparam logic [7:0] V_CTL [NV] = '{8'h00, 8'h00, 8'h09, 8'h8A, 8'h13, 8'h07};
  localparam int         V_PER [NV] = '{60,    60,    320,   480,   2400,  7680};
  localparam string      V_REQ [NV] = '{"R1", "R3", "R1", "R2", "R1", "R8"};

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] h, input logic [7:0] c);
    @(negedge clk);
    hp_we = 1'b1; hp_wdata = h; ctl_we = 1'b1; ctl_wdata = c;
    @(negedge clk);
    hp_we = 1'b0; ctl_we = 1'b0;
  endtask

  // Counts falling edges until tick is seen; optional write at edge 10
  task automatic gap(input bit do_wr, input logic [7:0] h, input logic [7:0] c,
                     output int n);
    n = 0;
    while (n < 20000) begin
      @(negedge clk);
      n++;
      if (do_wr && n == 10) begin
        hp_we = 1'b1; hp_wdata = h; ctl_we = 1'b1; ctl_wdata = c;
      end else begin
        hp_we = 1'b0; ctl_we = 1'b0;
      end
      if (tick) break;
    end
  endtask

  task automatic start_run(output int n);
    @(negedge clk);
    en = 1'b1;
    gap(1'b0, 8'h0, 8'h0, n);
  endtask

  task automatic pulse_width(input string req);
    @(negedge clk);
    chk(req, int'(tick), 0);
  endtask

  initial begin
    #900us;
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R4 tick low after reset", int'(tick), 0);
    start_run(n);
    chk("R4 default first tick", n, 750);
    gap(1'b0, 8'h0, 8'h0, n);
    chk("R4 default spacing", n, 750);

    // table walk
    for (int i = 0; i < NV; i++) begin
      @(negedge clk); en = 1'b0;
      wr(V_HP[i], V_CTL[i]);
      start_run(n);
      chk({V_REQ[i], " R6 first tick"}, n, V_PER[i]);
      pulse_width("R5");
      gap(1'b0, 8'h0, 8'h0, n);
      chk({V_REQ[i], " spacing"}, n + 1, V_PER[i]);
    end

    // R6: quiet while disabled, restart from zero
    @(negedge clk); en = 1'b0;
    wr(8'd5, 8'h00);
    begin
      int seen = 0;
      for (int k = 0; k < 200; k++) begin
        @(negedge clk);
        if (tick) seen++;
      end
      chk("R6 ticks while disabled", seen, 0);
    end
    start_run(n);
    chk("R6 restart first tick", n, 60);

    // R7: mid-run update waits for the terminal count
    gap(1'b1, 8'd7, 8'h00, n);
    chk("R7 period in progress keeps old spacing", n, 60);
    gap(1'b0, 8'h0, 8'h0, n);
    chk("R7 new spacing after terminal count", n, 80);

    // R3: zero half-period is clamped
    @(negedge clk); en = 1'b0;
    wr(8'd0, 8'h00);
    start_run(n);
    chk("R3 zero clamped", n, 60);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule